// File: doc/BRIEF.md
# Profiling Register Access Permission Checker

This block decides what happens when software tries to read or write a protected profiling control register. Each access request carries the current privilege level (0 to 3), the access direction, and a snapshot of the debug, security, hypervisor and nested-virtualisation control bits. The block works through a fixed priority chain and returns one of five verdicts: perform the access, raise an undefined-instruction fault, trap to level 2, trap to level 3, or redirect the access to a memory slot.

The verdict is registered. It appears together with a one-cycle valid pulse on the clock edge after the request strobe, and it stays on the outputs until the next request. Trap verdicts carry a fixed 6-bit exception class. A redirect carries the byte offset of the memory slot. The logic that takes the exception or performs the access lies outside this block.

A parameter selects whether the halted-debug checks come before the hypervisor traps. When it is set, an access that the security checks would block gives an undefined verdict at once, provided the core is halted, the top level exists and secure debug is disabled.

Top module: `privreg_access_check`

## Requirements
- R1: A request at privilege level 0 gives verdict code 1 (undefined), whatever the other inputs are.
- R2: A request at privilege level 3 gives verdict code 0 (access), whatever the other inputs are.
- R3: The access is "blocked" when the secure state (ns=0) has an ownership field other than 2'b01, when the non-secure state (ns=1) has an ownership field other than 2'b11, or when the profiling enable is 0. At level 1 or 2, with HALT_TRAP_PRIO=1, a blocked access with halted=1, top level present and secure debug disabled gives code 1 before any other check.
- R4: At level 1 with the second level enabled, the access gives code 2 (trap to level 2) when the top level is present with the fine-grained enable at 0. It also gives code 2 when the fine-grained bit for its direction is 0: the read bit for reads and the write bit for writes.
- R5: At level 1 with the second level enabled, a second-level profiling trap bit of 1 gives code 2, provided no earlier check has decided.
- R6: If no earlier check has decided, a blocked access with the top level present gives code 3 (trap to level 3). When halted=1 and secure debug is disabled, it gives code 1 instead.
- R7: At level 1 with the second level enabled and the nested-virtualisation bits {nv[2],nv[0]} equal to 2'b11 (nv[1] is ignored), an access that no check has trapped gives code 4 (redirect). The offset output is then 12'h850.
- R8: At level 2 the hypervisor checks of R4, R5 and R7 do not apply. The verdict is never 2 or 4.
- R9: The class output is 6'h18 for codes 2 and 3 and 0 for all other codes. The offset output is 0 unless the code is 4.
- R10: The valid output pulses high in the cycle after a request and is low otherwise. The verdict holds between requests. After reset, valid, code, class and offset are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request strobe |
| lvl | input | 2 | Privilege level of the access |
| is_write | input | 1 | 1 = write, 0 = read |
| halted | input | 1 | Core is in halted debug state |
| sec_dbg_off | input | 1 | Secure debug disabled |
| top_present | input | 1 | Level 3 is implemented |
| ns | input | 1 | Non-secure state |
| buf_owner | input | 2 | Profiling buffer ownership field |
| prof_en | input | 1 | Profiling enable from level 3 |
| l2_en | input | 1 | Second level enabled |
| fgt_en | input | 1 | Fine-grained trap enable from level 3 |
| fg_rd_ok | input | 1 | Fine-grained read permit (0 traps) |
| fg_wr_ok | input | 1 | Fine-grained write permit (0 traps) |
| l2_prof_trap | input | 1 | Second-level profiling trap |
| nv | input | 3 | Nested-virtualisation control bits |
| vld | output | 1 | Verdict valid pulse |
| verdict | output | 3 | Verdict code |
| exc_class | output | 6 | Exception class for trap verdicts |
| mem_ofs | output | 12 | Redirect byte offset |

## Verification
The hardest cases to reach are those where several rules apply at once. One example is a level-1 write that is blocked, halted and fine-grained-trapped in the same request: the order of the chain alone then picks the verdict. Another is a redirect pattern hidden behind a level-3 trap. To reach all of these, the bench walks every combination of the seventeen decision inputs, with nv[1] toggled as a pseudo-random don't-care, and issues one request per cycle. Each verdict is compared with an arithmetic model of the chain, and the check is tagged with the rule that decided it.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
   typedef enum logic [2:0] {
      V_ACCESS = 3'd0,
      V_UNDEF  = 3'd1,
      V_TRAP2  = 3'd2,
      V_TRAP3  = 3'd3,
      V_REDIR  = 3'd4
   } verdict_e;

   typedef struct packed {
      logic halt_undef;
      logic hyp_trap;
      logic top_trap;
      logic top_undef;
      logic redirect;
   } cond_t;
endpackage

// File: rtl/pcg_secure_gate.sv
module pcg_secure_gate #(
   parameter int          OWN_W     = 2,
   parameter logic [1:0]  SEC_OWN   = 2'b01,
   parameter logic [1:0]  NS_OWN    = 2'b11,
   parameter bit          HALT_PRIO = 1'b1
) (
   input  logic             top_present,
   input  logic             ns,
   input  logic [OWN_W-1:0] buf_owner,
   input  logic             prof_en,
   input  logic             halted,
   input  logic             sec_dbg_off,
   output logic             blocked,
   output logic             halt_undef,
   output logic             top_trap,
   output logic             top_undef
);
   logic own_bad;
   logic dbg_lock;

   initial begin
      assert (OWN_W == 2) else $error("OWN_W must be 2");
   end

   always_comb begin
      own_bad  = ns ? (buf_owner != NS_OWN) : (buf_owner != SEC_OWN);
      blocked  = own_bad || !prof_en;
      dbg_lock = halted && sec_dbg_off;
   end

   generate
      if (HALT_PRIO) begin : g_early
         assign halt_undef = dbg_lock && top_present && blocked;
      end else begin : g_late
         assign halt_undef = 1'b0;
      end
   endgenerate

   assign top_trap  = top_present && blocked && !dbg_lock;
   assign top_undef = top_present && blocked && dbg_lock;
endmodule

// File: rtl/pcg_hyp_gate.sv
module pcg_hyp_gate #(
   parameter int NV_W = 3
) (
   input  logic            at_l1,
   input  logic            l2_en,
   input  logic            top_present,
   input  logic            fgt_en,
   input  logic            is_write,
   input  logic            fg_rd_ok,
   input  logic            fg_wr_ok,
   input  logic            l2_prof_trap,
   input  logic [NV_W-1:0] nv,
   output logic            hyp_trap,
   output logic            redirect
);
   localparam int NV_HI = NV_W - 1;

   logic active;
   logic fg_block;
   logic dir_ok;

   initial begin
      assert (NV_W == 3) else $error("NV_W must be 3");
   end

   always_comb begin
      active   = at_l1 && l2_en;
      dir_ok   = is_write ? fg_wr_ok : fg_rd_ok;
      fg_block = (top_present && !fgt_en) || !dir_ok;
      hyp_trap = active && (fg_block || l2_prof_trap);
      redirect = active && nv[NV_HI] && nv[0];
   end
endmodule

// File: rtl/pcg_resolver.sv
module pcg_resolver
   import pcg_pkg::*;
#(
   parameter int LVL_W = 2
) (
   input  logic [LVL_W-1:0] lvl,
   input  cond_t            c,
   output verdict_e         v
);
   localparam logic [LVL_W-1:0] LVL_USER = '0;
   localparam logic [LVL_W-1:0] LVL_TOP  = {LVL_W{1'b1}};

   always_comb begin
      if (lvl == LVL_USER)      v = V_UNDEF;
      else if (lvl == LVL_TOP)  v = V_ACCESS;
      else if (c.halt_undef)    v = V_UNDEF;
      else if (c.hyp_trap)      v = V_TRAP2;
      else if (c.top_undef)     v = V_UNDEF;
      else if (c.top_trap)      v = V_TRAP3;
      else if (c.redirect)      v = V_REDIR;
      else                      v = V_ACCESS;
   end
endmodule

// File: rtl/privreg_access_check.sv
module privreg_access_check
   import pcg_pkg::*;
#(
   parameter int           LVL_W          = 2,
   parameter int           CLASS_W        = 6,
   parameter int           OFS_W          = 12,
   parameter int           NV_W           = 3,
   parameter int           OWN_W          = 2,
   parameter logic [5:0]   TRAP_CLASS     = 6'h18,
   parameter logic [11:0]  REDIR_OFS      = 12'h850,
   parameter bit           HALT_TRAP_PRIO = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [LVL_W-1:0]   lvl,
   input  logic               is_write,
   input  logic               halted,
   input  logic               sec_dbg_off,
   input  logic               top_present,
   input  logic               ns,
   input  logic [OWN_W-1:0]   buf_owner,
   input  logic               prof_en,
   input  logic               l2_en,
   input  logic               fgt_en,
   input  logic               fg_rd_ok,
   input  logic               fg_wr_ok,
   input  logic               l2_prof_trap,
   input  logic [NV_W-1:0]    nv,
   output logic               vld,
   output logic [2:0]         verdict,
   output logic [CLASS_W-1:0] exc_class,
   output logic [OFS_W-1:0]   mem_ofs
);
   localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

   initial begin
      assert (LVL_W == 2)     else $error("LVL_W must be 2");
      assert (CLASS_W >= 6)   else $error("CLASS_W too narrow");
      assert (OFS_W >= 12)    else $error("OFS_W too narrow");
   end

   cond_t    cnd;
   verdict_e v_nxt;
   logic     blocked;

   pcg_secure_gate #(
      .OWN_W(OWN_W), .HALT_PRIO(HALT_TRAP_PRIO)
   ) u_sec (
      .top_present(top_present), .ns(ns), .buf_owner(buf_owner),
      .prof_en(prof_en), .halted(halted), .sec_dbg_off(sec_dbg_off),
      .blocked(blocked), .halt_undef(cnd.halt_undef),
      .top_trap(cnd.top_trap), .top_undef(cnd.top_undef)
   );

   pcg_hyp_gate #(.NV_W(NV_W)) u_hyp (
      .at_l1(lvl == LVL_ONE), .l2_en(l2_en), .top_present(top_present),
      .fgt_en(fgt_en), .is_write(is_write), .fg_rd_ok(fg_rd_ok),
      .fg_wr_ok(fg_wr_ok), .l2_prof_trap(l2_prof_trap), .nv(nv),
      .hyp_trap(cnd.hyp_trap), .redirect(cnd.redirect)
   );

   pcg_resolver #(.LVL_W(LVL_W)) u_res (
      .lvl(lvl), .c(cnd), .v(v_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld       <= 1'b0;
         verdict   <= 3'd0;
         exc_class <= '0;
         mem_ofs   <= '0;
      end else begin
         vld <= req;
         if (req) begin
            verdict   <= v_nxt;
            exc_class <= (v_nxt == V_TRAP2 || v_nxt == V_TRAP3)
                         ? CLASS_W'(TRAP_CLASS) : '0;
            mem_ofs   <= (v_nxt == V_REDIR) ? OFS_W'(REDIR_OFS) : '0;
         end
      end
   end
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
   parameter int LVL_W   = 2,
   parameter int CLASS_W = 6,
   parameter int OFS_W   = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req,
   input logic [LVL_W-1:0]   lvl,
   input logic               vld,
   input logic [2:0]         verdict,
   input logic [CLASS_W-1:0] exc_class,
   input logic [OFS_W-1:0]   mem_ofs
);
   a_r1_user_undef: assert property (@(posedge clk) disable iff (!rst_n)
      (req && lvl == '0) |=> (verdict == 3'd1));
   a_r2_top_access: assert property (@(posedge clk) disable iff (!rst_n)
      (req && lvl == {LVL_W{1'b1}}) |=> (verdict == 3'd0));
   a_r8_no_hyp_at_l2: assert property (@(posedge clk) disable iff (!rst_n)
      (req && lvl == LVL_W'(2)) |=> (verdict != 3'd2 && verdict != 3'd4));
   a_r9_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && (verdict == 3'd2 || verdict == 3'd3)) |-> (exc_class == CLASS_W'(6'h18)));
   a_r9_no_class: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && verdict != 3'd2 && verdict != 3'd3) |-> (exc_class == '0));
   a_r7_redir_ofs: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && verdict == 3'd4) |-> (mem_ofs == OFS_W'(12'h850)));
   a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> vld);
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (!vld && $stable(verdict)));
   a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> (verdict <= 3'd4));
endmodule

bind privreg_access_check pcg_checker #(
   .LVL_W(LVL_W), .CLASS_W(CLASS_W), .OFS_W(OFS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .lvl(lvl), .vld(vld),
   .verdict(verdict), .exc_class(exc_class), .mem_ofs(mem_ofs)
);

// File: tb/sim_privreg_access_check.sv
module sim_privreg_access_check;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [1:0]  lvl = '0;
   logic        is_write = 0, halted = 0, sec_dbg_off = 0, top_present = 0, ns = 0;
   logic [1:0]  buf_owner = '0;
   logic        prof_en = 0, l2_en = 0, fgt_en = 0, fg_rd_ok = 0, fg_wr_ok = 0, l2_prof_trap = 0;
   logic [2:0]  nv = '0;
   logic        vld;
   logic [2:0]  verdict;
   logic [5:0]  exc_class;
   logic [11:0] mem_ofs;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   privreg_access_check u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .lvl(lvl), .is_write(is_write),
      .halted(halted), .sec_dbg_off(sec_dbg_off), .top_present(top_present),
      .ns(ns), .buf_owner(buf_owner), .prof_en(prof_en), .l2_en(l2_en),
      .fgt_en(fgt_en), .fg_rd_ok(fg_rd_ok), .fg_wr_ok(fg_wr_ok),
      .l2_prof_trap(l2_prof_trap), .nv(nv), .vld(vld), .verdict(verdict),
      .exc_class(exc_class), .mem_ofs(mem_ofs)
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Model of the priority chain; tag names the rule that decided.
   task automatic model(input logic [16:0] v, output int code, output string tag);
      logic [1:0] l;
      logic blk, dbg, dir_ok;
      l = v[1:0];
      blk = (v[6] ? (v[8:7] != 2'b11) : (v[8:7] != 2'b01)) || !v[9];
      dbg = v[3] && v[4];
      dir_ok = v[2] ? v[13] : v[12];
      if (l == 0)                                    begin code = 1; tag = "R1"; end
      else if (l == 3)                               begin code = 0; tag = "R2"; end
      else if (dbg && v[5] && blk)                   begin code = 1; tag = "R3"; end
      else if (l == 1 && v[10] && ((v[5] && !v[11]) || !dir_ok))
                                                     begin code = 2; tag = "R4"; end
      else if (l == 1 && v[10] && v[14])             begin code = 2; tag = "R5"; end
      else if (v[5] && blk)                          begin code = dbg ? 1 : 3; tag = "R6"; end
      else if (l == 1 && v[10] && v[15] && v[16])    begin code = 4; tag = "R7"; end
      else                                           begin code = 0; tag = (l == 2) ? "R8" : "R7"; end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int ecode;
      string etag;
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset vld", vld, 0);
      check("R10 reset verdict", verdict, 0);
      check("R10 reset class", exc_class, 0);
      check("R10 reset ofs", mem_ofs, 0);
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < (1 << 17); i++) begin
         logic [16:0] v;
         v = 17'(i);
         @(negedge clk);
         req = 1'b1;
         lvl = v[1:0]; is_write = v[2]; halted = v[3]; sec_dbg_off = v[4];
         top_present = v[5]; ns = v[6]; buf_owner = v[8:7]; prof_en = v[9];
         l2_en = v[10]; fgt_en = v[11]; fg_rd_ok = v[12]; fg_wr_ok = v[13];
         l2_prof_trap = v[14]; nv = {v[15], ^v[3:0], v[16]};
         model(v, ecode, etag);
         @(posedge clk); #1;
         check({etag, " verdict"}, verdict, ecode);
         check("R10 vld", vld, 1);
         check("R9 class", exc_class, (ecode == 2 || ecode == 3) ? 6'h18 : 0);
         check("R9 ofs", mem_ofs, (ecode == 4) ? 12'h850 : 0);
         if (i == (1 << 17) - 1) begin
            @(negedge clk); req = 1'b0; lvl = 2'd3;
            @(posedge clk); #1;
            check("R10 idle vld", vld, 0);
            check("R10 hold verdict", verdict, ecode);
         end
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule